// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous request port to an external asynchronous static RAM with a 16-bit data path, 17 address bits and one active-low select per byte lane. A requester offers an access with a valid/ready handshake. The access carries a read/write flag, an address, write data and a lane mask. The controller then plays the strobe sequence that the memory needs. Chip enable and the lane selects are asserted first. Next comes either a write-enable pulse or an output-enable window. Last comes a short tail before the memory is deselected.

The length of each phase is a whole number of clock cycles. It is derived at elaboration from nanosecond timing parameters as ceiling(time / clock period), with a floor of one cycle. This covers the minimum write pulse, data setup, address-to-write-end, read access and cycle times. During writes, output enable stays high and the controller's own data drivers are switched on only after write enable has fallen, so the data bus is never driven from both sides. Reads return one valid pulse carrying the enabled lanes, and disabled lanes read as zero.

Top module: `asram_bridge`

## Requirements
- R1: A write keeps chip enable low for the whole access. Write enable falls one cycle after chip enable and stays low for the write strobe length (4 cycles at defaults). Output enable stays high during the entire write, and write enable and output enable are never low together.
- R2: Mask bit 0 selects the lower lane (data bits 7:0, select bit 0) and mask bit 1 selects the upper lane (bits 15:8, select bit 1); a 1 enables the lane. A disabled lane's select stays high and its stored byte is left unchanged. A strobe is never low unless chip enable is low and at least one select is low.
- R3: The data driver enable rises exactly one cycle after write enable falls and falls exactly one cycle after write enable rises. It is never high while output enable is low. The driven data is held for at least the data-setup time before write enable rises.
- R4: A read keeps write enable high. Output enable falls one cycle after chip enable and stays low for the read strobe length (5 cycles at defaults). The bus is sampled in the last cycle of that window, which meets both the address-to-data and the output-enable-to-data times.
- R5: Each read returns a read-valid pulse exactly one cycle long, raised in the cycle in which output enable has just returned high. Disabled lanes of the returned data are zero.
- R6: Ready is high only while idle, and a request is taken in a cycle where valid and ready are both high. Address, data, mask and direction are latched at that edge, and later changes on the request inputs do not affect the access in flight.
- R7: Counted from the accepting edge, ready stays low for 6 cycles for a write and 7 cycles for a read at the default timing.
- R8: After reset, chip enable, write enable, output enable and both selects are high, the driver enable and read-valid are low, and ready is high.
- R9: A request with mask 00 is accepted but asserts no memory strobe and leaves memory contents unchanged. Ready is low for one cycle. For a read, a read-valid pulse with all-zero data comes in that cycle.
- R10: The memory address stays constant for as long as chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 lower byte, bit 1 upper byte |
| rd_valid | output | 1 | One-cycle read result pulse |
| rd_data | output | 16 | Read result, disabled lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bsel_n | output | 2 | Lane selects, active low, bit 0 lower byte |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Data returned from memory |

## Verification
Two events share a clock edge. The read-data capture falls on the same edge where output enable is lifted, and the write-driver release falls on the edge that deselects the memory (one-cycle tail). The bench memory model returns valid data only after output enable has been low for the access time and the address has been stable long enough, and it returns junk as soon as output enable rises. A capture placed one cycle early or one cycle late therefore comes back as wrong data. A monitor on every write-enable edge measures the pulse width, the data driving time before the rising edge, and how long the driver lingers afterwards, and it flags any overlap of the driver with output enable.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_t;

   // ceiling(t_ns / per_ns), never below one cycle
   function automatic int ns_to_cyc(input int t_ns, input int per_ns);
      int c;
      c = (t_ns + per_ns - 1) / per_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      return max2(max2(a, b), c);
   endfunction

endpackage

// File: rtl/asram_lane.sv
module asram_lane #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              en_in,
   input  logic [LANE_W-1:0] wdata_in,
   input  logic              cap,
   input  logic              release_i,
   input  logic [LANE_W-1:0] dq_in,
   output logic              sel_n,
   output logic [LANE_W-1:0] dq_out,
   output logic [LANE_W-1:0] rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_n  <= 1'b1;
         dq_out <= '0;
         rdata  <= '0;
      end else begin
         if (accept) begin
            sel_n  <= ~en_in;
            dq_out <= wdata_in;
            rdata  <= '0;
         end else begin
            if (release_i) begin
               sel_n <= 1'b1;
            end
            if (cap && !sel_n) begin
               rdata <= dq_in;
            end
         end
      end
   end

   AST_LANE_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && sel_n) |=> (rdata == '0));  // R5

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 10,
   parameter int T_WC_NS       = 55,
   parameter int T_PWE_NS      = 40,
   parameter int T_SD_NS       = 25,
   parameter int T_AW_NS       = 45,
   parameter int T_RC_NS       = 55,
   parameter int T_AA_NS       = 55,
   parameter int T_DOE_NS      = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   input  logic req_null,
   output logic req_ready,
   output logic accept,
   output logic cap_rd,
   output logic release_o,
   output logic ce_n,
   output logic we_n,
   output logic oe_n,
   output logic drive,
   output logic rd_valid
);

   localparam int SETUP_CYC = 1;
   localparam int WR_STB = max3(ns_to_cyc(T_PWE_NS, CLK_PERIOD_NS),
                                ns_to_cyc(T_SD_NS, CLK_PERIOD_NS) + 1,
                                ns_to_cyc(T_AW_NS, CLK_PERIOD_NS) - SETUP_CYC);
   localparam int WR_HLD = max2(1, ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - SETUP_CYC - WR_STB);
   localparam int RD_STB = max2(ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS),
                                ns_to_cyc(T_AA_NS, CLK_PERIOD_NS) - SETUP_CYC);
   localparam int RD_HLD = max2(1, ns_to_cyc(T_RC_NS, CLK_PERIOD_NS) - SETUP_CYC - RD_STB);
   localparam int CNT_MAX = max3(max2(WR_STB, WR_HLD), max2(RD_STB, RD_HLD), SETUP_CYC);
   localparam int CNT_W = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

   phase_t           phase;
   logic [CNT_W-1:0] cnt;
   logic             is_wr;
   logic             last;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;
   assign last      = (cnt == '0);
   assign cap_rd    = (phase == PH_STROBE) && !is_wr && last;
   assign release_o = (phase == PH_HOLD) && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt      <= '0;
         is_wr    <= 1'b0;
         ce_n     <= 1'b1;
         we_n     <= 1'b1;
         oe_n     <= 1'b1;
         drive    <= 1'b0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         drive    <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (accept) begin
                  is_wr <= req_write;
                  if (req_null) begin
                     phase    <= PH_HOLD;
                     cnt      <= '0;
                     rd_valid <= !req_write;
                  end else begin
                     phase <= PH_SETUP;
                     cnt   <= CNT_W'(SETUP_CYC - 1);
                     ce_n  <= 1'b0;
                  end
               end
            end
            PH_SETUP: begin
               if (last) begin
                  phase <= PH_STROBE;
                  cnt   <= is_wr ? CNT_W'(WR_STB - 1) : CNT_W'(RD_STB - 1);
                  if (is_wr) we_n <= 1'b0;
                  else       oe_n <= 1'b0;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_STROBE: begin
               drive <= is_wr;
               if (last) begin
                  phase    <= PH_HOLD;
                  cnt      <= is_wr ? CNT_W'(WR_HLD - 1) : CNT_W'(RD_HLD - 1);
                  we_n     <= 1'b1;
                  oe_n     <= 1'b1;
                  rd_valid <= !is_wr;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_HOLD: begin
               if (last) begin
                  phase <= PH_IDLE;
                  ce_n  <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n));  // R1
   AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> oe_n);  // R3
   AST_DRIVE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> !drive);  // R3
   AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |=> !drive);  // R3
   AST_RDV_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);  // R5
   AST_READY_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> ce_n);  // R6

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge #(
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 16,
   parameter int CLK_PERIOD_NS = 10,
   parameter int T_WC_NS       = 55,
   parameter int T_PWE_NS      = 40,
   parameter int T_SD_NS       = 25,
   parameter int T_AW_NS       = 45,
   parameter int T_RC_NS       = 55,
   parameter int T_AA_NS       = 55,
   parameter int T_DOE_NS      = 25,
   localparam int LANE_W       = 8,
   localparam int LANES        = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [LANES-1:0]  mem_bsel_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   if (DATA_W < LANE_W || (DATA_W % LANE_W) != 0) begin : g_bad_width
      $error("DATA_W must be a non-zero multiple of the lane width");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (CLK_PERIOD_NS < 1) begin : g_bad_clk
      $error("CLK_PERIOD_NS must be positive");
   end

   logic accept;
   logic cap_rd;
   logic release_w;

   asram_seq #(
      .CLK_PERIOD_NS (CLK_PERIOD_NS),
      .T_WC_NS       (T_WC_NS),
      .T_PWE_NS      (T_PWE_NS),
      .T_SD_NS       (T_SD_NS),
      .T_AW_NS       (T_AW_NS),
      .T_RC_NS       (T_RC_NS),
      .T_AA_NS       (T_AA_NS),
      .T_DOE_NS      (T_DOE_NS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_null  (~|req_mask),
      .req_ready (req_ready),
      .accept    (accept),
      .cap_rd    (cap_rd),
      .release_o (release_w),
      .ce_n      (mem_ce_n),
      .we_n      (mem_we_n),
      .oe_n      (mem_oe_n),
      .drive     (mem_dq_oe),
      .rd_valid  (rd_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr <= '0;
      end else if (accept) begin
         mem_addr <= req_addr;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      asram_lane #(.LANE_W(LANE_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .accept    (accept),
         .en_in     (req_mask[g]),
         .wdata_in  (req_wdata[g*LANE_W +: LANE_W]),
         .cap       (cap_rd),
         .release_i (release_w),
         .dq_in     (mem_dq_in[g*LANE_W +: LANE_W]),
         .sel_n     (mem_bsel_n[g]),
         .dq_out    (mem_dq_out[g*LANE_W +: LANE_W]),
         .rdata     (rd_data[g*LANE_W +: LANE_W])
      );
   end

   AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n || !mem_oe_n) |-> (!mem_ce_n && !(&mem_bsel_n)));  // R2
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));  // R10
   AST_SEL_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !(&mem_bsel_n) |-> !mem_ce_n);  // R9

endmodule

// File: tb/asram_bridge_bench.sv
module asram_bridge_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic [16:0] mem_addr;
   logic        mem_ce_n, mem_we_n, mem_oe_n;
   logic [1:0]  mem_bsel_n;
   logic [15:0] mem_dq_out;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_in = 16'hC3C3;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   asram_bridge u_asram_bridge (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_bsel_n(mem_bsel_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [15:0] mdl [int];
   logic [15:0] shadow [int];
   int oe_cnt = 0, a_cnt = 0, we_lo = 0, drv_lo = 0;
   logic [16:0] last_addr = '0;
   logic prev_we = 1'b1;

   always @(negedge clk) begin
      logic [15:0] word;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) oe_cnt++; else oe_cnt = 0;
      if (mem_ce_n) a_cnt = 0;
      else if (mem_addr != last_addr) a_cnt = 1;
      else a_cnt++;
      last_addr = mem_addr;
      word = mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 16'h0000;
      if (oe_cnt * 10 >= 25 && a_cnt * 10 >= 55) begin
         mem_dq_in[7:0]  = mem_bsel_n[0] ? 8'hC3 : word[7:0];
         mem_dq_in[15:8] = mem_bsel_n[1] ? 8'hC3 : word[15:8];
      end else begin
         mem_dq_in = 16'hC3C3;
      end
      // write-side monitor
      if (!mem_we_n) we_lo++; else we_lo = 0;
      if (!mem_we_n && mem_dq_oe) drv_lo++; else if (mem_we_n) drv_lo = 0;
      if (mem_dq_oe && !mem_oe_n) chk(0, "R3 driver with output enable", 1, 0);
      if (mem_dq_oe && !mem_we_n && prev_we) chk(0, "R3 driver early", 1, 0);
      if (mem_dq_oe && mem_we_n && prev_we) chk(0, "R3 driver late release", 1, 0);
      if (!mem_we_n && !mem_oe_n) chk(0, "R1 we/oe overlap", 1, 0);
      prev_we = mem_we_n;
   end

   always @(posedge mem_we_n) begin
      if (rst_n) begin
         logic [15:0] word;
         chk(we_lo * 10 >= 40, "R1 write pulse width", we_lo, 4);
         chk(drv_lo * 10 >= 25, "R3 data setup", drv_lo, 3);
         chk(mem_dq_oe == 1'b1 && mem_ce_n == 1'b0, "R3 driving at write end", {mem_dq_oe, mem_ce_n}, 2'b10);
         word = mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 16'h0000;
         if (!mem_bsel_n[0]) word[7:0]  = mem_dq_out[7:0];
         if (!mem_bsel_n[1]) word[15:8] = mem_dq_out[15:8];
         mdl[int'(mem_addr)] = word;
      end
   end

   // ---------------- request runner ----------------
   int r_busy, r_ce, r_we, r_oe, r_we_first, r_oe_first, r_rdv, r_rdv_oe;
   logic [15:0] r_rdata;
   logic [1:0]  r_bsel;

   task automatic run_req(input bit w, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
      int k;
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
      @(posedge clk);
      #1;
      req_valid = 1'b0; req_write = ~w; req_addr = ~a; req_wdata = d ^ 16'h5A5A; req_mask = ~m;
      r_busy = 0; r_ce = 0; r_we = 0; r_oe = 0; r_we_first = 0; r_oe_first = 0;
      r_rdv = 0; r_rdv_oe = 0; r_rdata = '0; r_bsel = 2'b11;
      k = 0;
      while (1) begin
         @(negedge clk);
         if (req_ready) break;
         k++;
         if (!mem_ce_n) begin
            r_ce++;
            if (r_ce == 1) r_bsel = mem_bsel_n;
         end
         if (!mem_we_n) begin r_we++; if (r_we_first == 0) r_we_first = k; end
         if (!mem_oe_n) begin r_oe++; if (r_oe_first == 0) r_oe_first = k; end
         if (rd_valid) begin r_rdv++; r_rdata = rd_data; r_rdv_oe = mem_oe_n; end
      end
      r_busy = k;
      if (rd_valid) r_rdv++;
      if (w && m != 2'b00) begin
         logic [15:0] s;
         s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
         if (m[0]) s[7:0] = d[7:0];
         if (m[1]) s[15:8] = d[15:8];
         shadow[int'(a)] = s;
      end
   endtask

   function automatic logic [15:0] expect_rd(input logic [16:0] a, input logic [1:0] m);
      logic [15:0] s;
      s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
      return {m[1] ? s[15:8] : 8'h00, m[0] ? s[7:0] : 8'h00};
   endfunction

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(req_ready == 1'b1, "R8 ready after reset", req_ready, 1);
      chk({mem_ce_n, mem_we_n, mem_oe_n, mem_bsel_n} == 5'b11111, "R8 strobes high",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_bsel_n}, 5'b11111);
      chk(mem_dq_oe == 1'b0 && rd_valid == 1'b0, "R8 driver and valid low", {mem_dq_oe, rd_valid}, 0);
   endtask

   task automatic t_write_full(input logic [16:0] a, input logic [15:0] d);
      run_req(1'b1, a, d, 2'b11);
      chk(r_busy == 6, "R7 write occupancy", r_busy, 6);
      chk(r_ce == 6, "R1 ce low whole write", r_ce, 6);
      chk(r_we == 4 && r_we_first == 2, "R1 we pulse placement", {r_we[15:0], r_we_first[15:0]}, {16'd4, 16'd2});
      chk(r_oe == 0, "R1 oe high in write", r_oe, 0);
      chk(r_bsel == 2'b00, "R2 both lanes selected", r_bsel, 0);
   endtask

   task automatic t_read(input logic [16:0] a, input logic [1:0] m, input string tag);
      logic [15:0] e;
      e = expect_rd(a, m);
      run_req(1'b0, a, 16'h0, m);
      chk(r_busy == 7, "R7 read occupancy", r_busy, 7);
      chk(r_oe == 5 && r_oe_first == 2 && r_we == 0, "R4 oe window", {r_oe[7:0], r_oe_first[7:0], r_we[7:0]}, {8'd5, 8'd2, 8'd0});
      chk(r_rdv == 1 && r_rdv_oe == 1, "R5 single valid pulse after oe", {r_rdv[15:0], r_rdv_oe[15:0]}, {16'd1, 16'd1});
      chk(r_rdata == e, tag, r_rdata, e);
   endtask

   task automatic t_lanes();
      t_write_full(17'h00100, 16'h1111);
      run_req(1'b1, 17'h00100, 16'hAB22, 2'b10);
      chk(r_bsel == 2'b01, "R2 upper lane select", r_bsel, 2'b01);
      t_read(17'h00100, 2'b11, "R2 upper-only write merge");
      run_req(1'b1, 17'h00100, 16'h33CD, 2'b01);
      chk(r_bsel == 2'b10, "R2 lower lane select", r_bsel, 2'b10);
      t_read(17'h00100, 2'b11, "R2 lower-only write merge");
      t_read(17'h00100, 2'b01, "R5 upper lane zero on lower read");
      t_read(17'h00100, 2'b10, "R5 lower lane zero on upper read");
   endtask

   task automatic t_null();
      run_req(1'b1, 17'h00100, 16'hFFFF, 2'b00);
      chk(r_busy == 1 && r_ce == 0 && r_we == 0, "R9 null write no strobe", {r_busy[7:0], r_ce[7:0], r_we[7:0]}, {8'd1, 8'd0, 8'd0});
      t_read(17'h00100, 2'b11, "R9 null write left memory");
      run_req(1'b0, 17'h00100, 16'h0, 2'b00);
      chk(r_busy == 1 && r_ce == 0 && r_oe == 0, "R9 null read no strobe", {r_busy[7:0], r_ce[7:0], r_oe[7:0]}, {8'd1, 8'd0, 8'd0});
      chk(r_rdv == 1 && r_rdata == 16'h0, "R9 null read zero pulse", {r_rdv[15:0], r_rdata}, {16'd1, 16'h0});
   endtask

   task automatic t_sweep();
      for (int i = 0; i < 6; i++) begin
         logic [16:0] a;
         a = 17'h1FFFF ^ 17'(i * 37);
         t_write_full(a, 16'(16'h0F0F ^ (i * 16'h1357)));
      end
      for (int i = 5; i >= 0; i--) begin
         t_read(17'h1FFFF ^ 17'(i * 37), 2'b11, "R6 latched request data");
      end
   endtask

   initial begin
      #2_000_000;
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_full(17'h00005, 16'hBEEF);
      t_read(17'h00005, 2'b11, "R4 full read data");
      t_lanes();
      t_null();
      t_sweep();
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule